// File: doc/BRIEF.md
# Adaptive ADPCM Nibble Decoder

This block turns a stream of 4-bit adaptive delta codes into 16-bit signed samples. Each accepted code changes a running predictor by a signed amount. That amount is proportional to the current step size. The step size itself then grows or shrinks by a factor chosen from the code's magnitude. The block keeps the predictor, the sample from just before the last update, and the step in registers. It exposes all three so that a downstream stage can interpolate or scale them.

One code is consumed on each clock where the strobe is high. All arithmetic is fixed-point integer arithmetic, and results are clamped to fixed bounds. A synchronous restart input puts the decoder back to its starting state. Software uses it at the start of each new sample stream. Fetching the codes, pacing them, interpolating and volume control are left to neighbouring logic.

Top module: `adpcm_nibble_dec`

## Requirements
- R1: After the asynchronous reset, and in the cycle after a restart, sample_o is 0, prev_o is 0 and step_o is 127.
- R2: For an accepted code, code_i[3] is the sign and code_i[2:0] is the magnitude m. The predictor changes by (2m+1)*step/8. The division truncates toward zero. The change is added when the sign is 0 and subtracted when the sign is 1.
- R3: The new predictor saturates to the range -32768..32767.
- R4: The new step is step*f/64, truncated. The factor f is 57 for m = 0..3, 77 for m = 4, 102 for m = 5, 128 for m = 6 and 153 for m = 7. The sign bit has no effect on f.
- R5: The new step saturates to the range 127..24576.
- R6: On every accepted code, prev_o takes the value sample_o had before the update.
- R7: When valid_i is low and restart_i is low, sample_o, prev_o and step_o hold their values.
- R8: When restart_i and valid_i are both high in the same cycle, the restart takes effect and the code is discarded.
- R9: The results of an accepted code appear on the outputs at the clock edge that samples the strobe. They are visible in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Synchronous return to the initial decoder state |
| valid_i | input | 1 | Strobe: code_i is accepted this cycle |
| code_i | input | 4 | Sign bit 3, magnitude bits 2..0 |
| sample_o | output | 16 | Current predicted sample, two's complement |
| prev_o | output | 16 | Sample before the most recent update |
| step_o | output | 15 | Current adaptive step size |

## Verification
Both the predictor and the step are fed back into every following update. A single wrong step value therefore shows up at step_o in the very next cycle. It also bends every later sample, so one bad update cannot hide for long. The bench runs long one-sided code runs that drive both clamps hard, to catch saturation errors. It uses a pseudo-random stream, negative codes whose products end in a remainder, idle gaps, and a restart on its own and together with a strobe. A truncation error toward minus infinity shows on negative codes as a one-LSB drift in sample_o within one update.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;
  localparam int unsigned SAMPLE_W   = 16;
  localparam int unsigned STEP_W     = 15;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned STEP_INIT  = 127;
  localparam int unsigned STEP_MIN   = 127;
  localparam int unsigned STEP_MAX   = 24576;
  localparam int unsigned PRED_SHIFT = 3;   // divide by 8
  localparam int unsigned STEP_SHIFT = 6;   // divide by 64
  localparam int unsigned FACTOR_W   = 8;

  typedef struct packed {
    logic       neg;
    logic [2:0] mag;
  } code_t;
endpackage

// File: rtl/adpcm_pred_upd.sv
module adpcm_pred_upd
  import adpcm_pkg::*;
#(
  parameter int unsigned SMP_W = SAMPLE_W,
  parameter int unsigned STP_W = STEP_W
) (
  input  logic signed [SMP_W-1:0] pred_i,
  input  logic        [STP_W-1:0] step_i,
  input  code_t                   code_i,
  output logic signed [SMP_W-1:0] pred_o
);
  localparam int unsigned PROD_W = STP_W + 4;
  localparam int unsigned SUM_W  = ((SMP_W > PROD_W) ? SMP_W : PROD_W) + 2;
  localparam logic signed [SUM_W-1:0] SUM_HI = SUM_W'((2 ** (SMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SUM_LO = -SUM_HI - SUM_W'(1);

  logic        [3:0]        mult;
  logic        [PROD_W-1:0] prod;
  logic        [PROD_W-1:0] mag_q;
  logic signed [SUM_W-1:0]  ext_pred;
  logic signed [SUM_W-1:0]  ext_mag;
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    mult     = {code_i.mag, 1'b1};
    prod     = PROD_W'(mult) * PROD_W'(step_i);
    // magnitude first, sign after: truncation toward zero
    mag_q    = prod >> PRED_SHIFT;
    ext_pred = SUM_W'(pred_i);
    ext_mag  = $signed({{(SUM_W - PROD_W){1'b0}}, mag_q});
    sum      = code_i.neg ? (ext_pred - ext_mag) : (ext_pred + ext_mag);
    if (sum > SUM_HI)      pred_o = SMP_W'(SUM_HI);
    else if (sum < SUM_LO) pred_o = SMP_W'(SUM_LO);
    else                   pred_o = SMP_W'(sum);
  end
endmodule

// File: rtl/adpcm_step_adapt.sv
module adpcm_step_adapt
  import adpcm_pkg::*;
#(
  parameter int unsigned STP_W = STEP_W,
  parameter int unsigned S_MIN = STEP_MIN,
  parameter int unsigned S_MAX = STEP_MAX
) (
  input  logic [STP_W-1:0] step_i,
  input  logic [2:0]       mag_i,
  output logic [STP_W-1:0] step_o
);
  localparam int unsigned PROD_W = STP_W + FACTOR_W;
  localparam logic [PROD_W-1:0] P_MIN = PROD_W'(S_MIN);
  localparam logic [PROD_W-1:0] P_MAX = PROD_W'(S_MAX);

  logic [FACTOR_W-1:0] factor;
  logic [PROD_W-1:0]   prod;
  logic [PROD_W-1:0]   quot;

  always_comb begin
    unique case (mag_i)
      3'd4:    factor = 8'd77;
      3'd5:    factor = 8'd102;
      3'd6:    factor = 8'd128;
      3'd7:    factor = 8'd153;
      default: factor = 8'd57;
    endcase
  end

  always_comb begin
    prod = PROD_W'(step_i) * PROD_W'(factor);
    quot = prod >> STEP_SHIFT;
    if (quot > P_MAX)      step_o = STP_W'(P_MAX);
    else if (quot < P_MIN) step_o = STP_W'(P_MIN);
    else                   step_o = STP_W'(quot);
  end
endmodule

// File: rtl/adpcm_nibble_dec.sv
module adpcm_nibble_dec
  import adpcm_pkg::*;
#(
  parameter int unsigned SMP_W  = SAMPLE_W,
  parameter int unsigned STP_W  = STEP_W,
  parameter int unsigned S_INIT = STEP_INIT,
  parameter int unsigned S_MIN  = STEP_MIN,
  parameter int unsigned S_MAX  = STEP_MAX
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    restart_i,
  input  logic                    valid_i,
  input  logic [CODE_W-1:0]       code_i,
  output logic signed [SMP_W-1:0] sample_o,
  output logic signed [SMP_W-1:0] prev_o,
  output logic [STP_W-1:0]        step_o
);
  localparam logic [STP_W-1:0] STEP_RST = STP_W'(S_INIT);

  code_t                   code;
  logic signed [SMP_W-1:0] pred_q, prev_q, pred_d;
  logic        [STP_W-1:0] step_q, step_d;
  logic                    take;

  assign code = code_t'(code_i);
  assign take = valid_i && !restart_i;

  adpcm_pred_upd #(.SMP_W(SMP_W), .STP_W(STP_W)) i_pred (
    .pred_i (pred_q),
    .step_i (step_q),
    .code_i (code),
    .pred_o (pred_d)
  );

  adpcm_step_adapt #(.STP_W(STP_W), .S_MIN(S_MIN), .S_MAX(S_MAX)) i_step (
    .step_i (step_q),
    .mag_i  (code.mag),
    .step_o (step_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= '0;
      prev_q <= '0;
      step_q <= STEP_RST;
    end else if (restart_i) begin
      pred_q <= '0;
      prev_q <= '0;
      step_q <= STEP_RST;
    end else if (take) begin
      prev_q <= pred_q;
      pred_q <= pred_d;
      step_q <= step_d;
    end
  end

  assign sample_o = pred_q;
  assign prev_o   = prev_q;
  assign step_o   = step_q;

  a_r5_step_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q >= STP_W'(S_MIN)) && (step_q <= STP_W'(S_MAX)));

  a_r6_prev_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !restart_i) |=> (prev_o == $past(sample_o)));

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !restart_i) |=> ($stable(sample_o) && $stable(prev_o) && $stable(step_o)));

  a_r8_restart_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (sample_o == '0 && prev_o == '0 && step_o == STEP_RST));

  a_r2_pos_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !restart_i && !code_i[3]) |=> (sample_o >= $past(sample_o)));

  a_r2_neg_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !restart_i && code_i[3]) |=> (sample_o <= $past(sample_o)));

  a_r4_big_code_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !restart_i && code_i[2] && code_i[1]) |=> (step_o >= $past(step_o)));
endmodule

// File: tb/test_adpcm_nibble_dec.sv
module test_adpcm_nibble_dec;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              restart = 1'b0;
  logic              valid = 1'b0;
  logic [3:0]        code = 4'd0;
  logic signed [15:0] sample, prev;
  logic [14:0]       step;

  int checks = 0;
  int errors = 0;
  int m_s = 0, m_p = 0, m_st = 127;
  string tag = "R1";
  logic [15:0] lfsr = 16'hace1;

  always #5 clk = ~clk;

  adpcm_nibble_dec i_adpcm_nibble_dec (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .valid_i(valid),
    .code_i(code), .sample_o(sample), .prev_o(prev), .step_o(step)
  );

  function automatic int clampi(int v, int lo, int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int fac(int m);
    case (m)
      4: return 77;
      5: return 102;
      6: return 128;
      7: return 153;
      default: return 57;
    endcase
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = 0; m_p = 0; m_st = 127;
    end else if (restart) begin
      m_s = 0; m_p = 0; m_st = 127;
    end else if (valid) begin
      int mg, d;
      mg = (2 * int'(code[2:0]) + 1) * m_st / 8;
      d  = code[3] ? -mg : mg;
      m_p  = m_s;
      m_s  = clampi(m_s + d, -32768, 32767);
      m_st = clampi(m_st * fac(int'(code[2:0])) / 64, 127, 24576);
    end
  end

  task automatic check(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    check(tag, int'(sample), m_s, "sample_o");
    check(tag, int'(prev), m_p, "prev_o");
    check(tag, int'(step), m_st, "step_o");
  endtask

  // drive at negedge after comparing the previous edge's result (R9)
  task automatic cyc(logic v, logic r, logic [3:0] c);
    @(negedge clk);
    cmp_all();
    valid = v; restart = r; code = c;
  endtask

  task automatic run(int n, logic [3:0] c);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, c);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    tag = "R1";
    @(negedge clk);
    check("R1", int'(sample), 0, "reset sample");
    check("R1", int'(prev), 0, "reset prev");
    check("R1", int'(step), 127, "reset step");

    // single known update: code 7 from init -> +15*127/8=238, step 303
    cyc(1'b1, 1'b0, 4'h7);
    cyc(1'b0, 1'b0, 4'h0);
    check("R9", int'(sample), 238, "one-cycle sample");
    check("R4", int'(step), 303, "one-cycle step");

    // negative truncation: code 9 -> -(3*303/8)= -113
    cyc(1'b1, 1'b0, 4'h9);
    cyc(1'b0, 1'b0, 4'h0);
    check("R2", int'(sample), 125, "neg truncation");
    check("R6", int'(prev), 238, "prev after update");
    check("R5", int'(step), 269, "step after mag1");

    tag = "R7"; for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 4'h7);
    tag = "R5"; run(40, 4'h0);                     // step floor
    tag = "R3"; run(40, 4'h7);                     // step ceiling, sample max
    check("R3", int'(sample), 32767, "positive clamp");
    check("R5", int'(step), 24576, "step ceiling");
    tag = "R3"; run(40, 4'hf);                     // sample min
    check("R3", int'(sample), -32768, "negative clamp");
    tag = "R4"; run(20, 4'hc);
    tag = "R2";
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], 1'b0, lfsr[7:4]);
    end
    tag = "R1"; cyc(1'b0, 1'b1, 4'h0);
    cyc(1'b0, 1'b0, 4'h0);
    check("R1", int'(step), 127, "restart step");
    check("R1", int'(sample), 0, "restart sample");
    tag = "R6"; run(10, 4'h6);
    tag = "R8"; cyc(1'b1, 1'b1, 4'h7);
    cyc(1'b0, 1'b0, 4'h0);
    check("R8", int'(sample), 0, "restart+strobe sample");
    check("R8", int'(step), 127, "restart+strobe step");
    check("R8", int'(prev), 0, "restart+strobe prev");
    tag = "R2"; run(30, 4'hb);
    cyc(1'b0, 1'b0, 4'h0);
    @(negedge clk);
    cmp_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule